// File: doc/BRIEF.md
# Registration-Tracking L2 Line Directory

This block is the L2-side bookkeeping for cache lines whose synchronization word is registered to a single L1. Each line has a state (invalid, valid, dirty or registered), one synchronization word and one plain data word. When a line is registered, the synchronization word holds the owner's 7-bit core ID instead of data, so no separate pointer array is needed. The L2 is write-through for plain data and write-back for the synchronization word once an owner returns it. A simple array stands in for backing memory. Lines are addressed directly by index.

L1s send requests on a valid/ready stream. A request is accepted only when `req_ready` is high. Only one request is in service at a time. The response is held on `rsp_*` with `rsp_valid` high until `rsp_ready` is seen, and no new request is accepted before that. A registration request for a line owned by another L1, or an L2 eviction of a registered line, sends a probe to the owner on a valid/ready stream. The block then waits on the acknowledge stream for the owner's up-to-date value. While it waits, every new request is stalled.

Request codes on `req_op`: 0 plain read, 1 plain write, 2 acquire registration, 3 return registration (L1 eviction), 4 L2 eviction of the line.

Top module: `regdir`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `prb_valid` is 0. All lines are invalid, and the backing memory reads as zero.
- R2: A plain read (op 0) returns the line's plain word. On an invalid line, the line is first filled from backing memory and becomes valid. The response has `rsp_remote`=0 and `rsp_owner`=0.
- R3: A plain write (op 1) updates both the L2 plain word and backing memory (write-through). The value survives an L2 eviction and refill. The response data is 0.
- R4: Acquiring an unregistered line (op 2) grants it without a probe. `rsp_data` is the current synchronization word, taken from memory if the line was invalid. `rsp_remote`=0 and `rsp_owner`=requester.
- R5: Acquiring a line already registered to the requester sends no probe and returns `rsp_data`=0, `rsp_remote`=0 and `rsp_owner`=requester.
- R6: Acquiring a line registered to another core sends exactly one probe to that owner with `prb_evict`=0. The response carries the acknowledged value, `rsp_remote`=1 and `rsp_owner`=previous owner. The requester becomes the new owner.
- R7: A return from the owner (op 3) stores the value in the L2 synchronization word, marks the line dirty and ends registration. It answers `rsp_remote`=0 and `rsp_owner`=owner. A return from a non-owner changes nothing and answers `rsp_remote`=1, with `rsp_owner`=current owner (0 if the line is not registered).
- R8: An L2 eviction (op 4) of a registered line sends a probe with `prb_evict`=1 to the owner. It writes the acknowledged value to memory and invalidates the line. A dirty line is written back without a probe. The response is all zero.
- R9: A plain read or write to a registered line is served at the L2 with no probe. The owner is unchanged.
- R10: While a probe is outstanding, `req_ready` stays 0. `prb_*` and `rsp_*` hold steady under back-pressure, and only one request is in service at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_op | input | 3 | Request code |
| req_src | input | 7 | Requesting core ID |
| req_line | input | 4 | Line index |
| req_data | input | 32 | Write data or returned synchronization value |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_dst | output | 7 | Core the response is for |
| rsp_data | output | 32 | Response data |
| rsp_remote | output | 1 | Remote-owner flag (or ignored return) |
| rsp_owner | output | 7 | Owner ID reported with the response |
| prb_valid | output | 1 | Probe to an owning L1 valid |
| prb_ready | input | 1 | Probe taken |
| prb_dst | output | 7 | Core being probed |
| prb_line | output | 4 | Line being probed |
| prb_evict | output | 1 | 1 forced eviction, 0 ownership transfer |
| ack_valid | input | 1 | Owner's flush acknowledge valid |
| ack_ready | output | 1 | Block is waiting for an acknowledge |
| ack_data | input | 32 | Owner's up-to-date synchronization value |

## Verification
The bench targets ownership transfers between several cores, and checks that the previous owner, not the requester, is probed. A design that swapped them would report the wrong owner or lose the value. It also checks returns from non-owners, which a careless design would accept, corrupting the line. Forced L2 evictions of registered and dirty lines are followed by a refill that shows whether the owner's value reached memory. Plain writes to registered lines are checked to confirm that a later transfer still probes the original owner. Held responses and long acknowledge delays check that requests stall and that outputs stay steady.

// File: rtl/regdir_pkg.sv
package regdir_pkg;
  typedef enum logic [2:0] {
    OP_RD   = 3'd0,
    OP_WR   = 3'd1,
    OP_REG  = 3'd2,
    OP_REL  = 3'd3,
    OP_L2EV = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    LS_INV   = 2'd0,
    LS_VAL   = 2'd1,
    LS_DIRTY = 2'd2,
    LS_REG   = 2'd3
  } lstate_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_PRB  = 2'd1,
    F_WAIT = 2'd2,
    F_RSP  = 2'd3
  } fsm_e;
endpackage

// File: rtl/regdir_backing.sv
module regdir_backing #(
  parameter int NLINES = 16,
  parameter int DW     = 32,
  localparam int IW    = $clog2(NLINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_sync,
  output logic [DW-1:0] rd_plain,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_sync_en,
  input  logic [DW-1:0] wr_sync,
  input  logic          wr_plain_en,
  input  logic [DW-1:0] wr_plain
);
  logic [DW-1:0] sync_q  [NLINES];
  logic [DW-1:0] plain_q [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sync_q[g]  <= '0;
        plain_q[g] <= '0;
      end else begin
        if (wr_sync_en && wr_idx == IW'(g))  sync_q[g]  <= wr_sync;
        if (wr_plain_en && wr_idx == IW'(g)) plain_q[g] <= wr_plain;
      end
    end
  end

  assign rd_sync  = sync_q[rd_idx];
  assign rd_plain = plain_q[rd_idx];
endmodule

// File: rtl/regdir_store.sv
module regdir_store
  import regdir_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int DW     = 32,
  localparam int IW    = $clog2(NLINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output lstate_e       rd_state,
  output logic [DW-1:0] rd_sync,
  output logic [DW-1:0] rd_plain,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_state_en,
  input  lstate_e       wr_state,
  input  logic          wr_sync_en,
  input  logic [DW-1:0] wr_sync,
  input  logic          wr_plain_en,
  input  logic [DW-1:0] wr_plain
);
  lstate_e       st_q    [NLINES];
  logic [DW-1:0] sync_q  [NLINES];
  logic [DW-1:0] plain_q [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]    <= LS_INV;
        sync_q[g]  <= '0;
        plain_q[g] <= '0;
      end else begin
        if (wr_state_en && wr_idx == IW'(g)) st_q[g]    <= wr_state;
        if (wr_sync_en && wr_idx == IW'(g))  sync_q[g]  <= wr_sync;
        if (wr_plain_en && wr_idx == IW'(g)) plain_q[g] <= wr_plain;
      end
    end
  end

  assign rd_state = st_q[rd_idx];
  assign rd_sync  = sync_q[rd_idx];
  assign rd_plain = plain_q[rd_idx];
endmodule

// File: rtl/regdir_ctrl.sv
module regdir_ctrl
  import regdir_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int DW     = 32,
  parameter int IDW    = 7,
  localparam int IW    = $clog2(NLINES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [2:0]     req_op,
  input  logic [IDW-1:0] req_src,
  input  logic [IW-1:0]  req_line,
  input  logic [DW-1:0]  req_data,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [IDW-1:0] rsp_dst,
  output logic [DW-1:0]  rsp_data,
  output logic           rsp_remote,
  output logic [IDW-1:0] rsp_owner,
  output logic           prb_valid,
  input  logic           prb_ready,
  output logic [IDW-1:0] prb_dst,
  output logic [IW-1:0]  prb_line,
  output logic           prb_evict,
  input  logic           ack_valid,
  output logic           ack_ready,
  input  logic [DW-1:0]  ack_data,
  // line store
  output logic [IW-1:0]  idx,
  input  lstate_e        l2_state,
  input  logic [DW-1:0]  l2_sync,
  input  logic [DW-1:0]  l2_plain,
  output logic           l2_st_we,
  output lstate_e        l2_st_wd,
  output logic           l2_sy_we,
  output logic [DW-1:0]  l2_sy_wd,
  output logic           l2_pl_we,
  output logic [DW-1:0]  l2_pl_wd,
  // backing memory
  input  logic [DW-1:0]  mem_sync,
  input  logic [DW-1:0]  mem_plain,
  output logic           mem_sy_we,
  output logic [DW-1:0]  mem_sy_wd,
  output logic           mem_pl_we,
  output logic [DW-1:0]  mem_pl_wd
);
  fsm_e           fsm_q, fsm_d;
  op_e            op_q, op_d;
  logic [IDW-1:0] src_q, src_d;
  logic [IW-1:0]  line_q, line_d;
  logic [IDW-1:0] prev_q, prev_d;
  logic [DW-1:0]  rdat_q, rdat_d;
  logic           rrem_q, rrem_d;
  logic [IDW-1:0] rown_q, rown_d;

  op_e            cur_op;
  logic           is_inv, is_reg;
  logic [IDW-1:0] cur_owner;
  logic [DW-1:0]  sync_eff, plain_eff;

  assign cur_op    = op_e'(req_op);
  assign idx       = (fsm_q == F_IDLE) ? req_line : line_q;
  assign is_inv    = (l2_state == LS_INV);
  assign is_reg    = (l2_state == LS_REG);
  assign cur_owner = l2_sync[IDW-1:0];
  assign sync_eff  = is_inv ? mem_sync  : l2_sync;
  assign plain_eff = is_inv ? mem_plain : l2_plain;

  always_comb begin
    fsm_d  = fsm_q;
    op_d   = op_q;
    src_d  = src_q;
    line_d = line_q;
    prev_d = prev_q;
    rdat_d = rdat_q;
    rrem_d = rrem_q;
    rown_d = rown_q;
    l2_st_we  = 1'b0;
    l2_st_wd  = LS_INV;
    l2_sy_we  = 1'b0;
    l2_sy_wd  = '0;
    l2_pl_we  = 1'b0;
    l2_pl_wd  = '0;
    mem_sy_we = 1'b0;
    mem_sy_wd = '0;
    mem_pl_we = 1'b0;
    mem_pl_wd = '0;
    unique case (fsm_q)
      F_IDLE: begin
        if (req_valid) begin
          op_d   = cur_op;
          src_d  = req_src;
          line_d = req_line;
          rdat_d = '0;
          rrem_d = 1'b0;
          rown_d = '0;
          fsm_d  = F_RSP;
          unique case (cur_op)
            OP_RD: begin
              rdat_d = plain_eff;
              if (is_inv) begin
                l2_st_we = 1'b1;
                l2_st_wd = LS_VAL;
                l2_sy_we = 1'b1;
                l2_sy_wd = mem_sync;
                l2_pl_we = 1'b1;
                l2_pl_wd = mem_plain;
              end
            end
            OP_WR: begin
              l2_pl_we  = 1'b1;
              l2_pl_wd  = req_data;
              mem_pl_we = 1'b1;
              mem_pl_wd = req_data;
              if (is_inv) begin
                l2_st_we = 1'b1;
                l2_st_wd = LS_VAL;
                l2_sy_we = 1'b1;
                l2_sy_wd = mem_sync;
              end
            end
            OP_REG: begin
              if (is_reg) begin
                if (cur_owner == req_src) begin
                  rown_d = req_src;
                end else begin
                  prev_d = cur_owner;
                  fsm_d  = F_PRB;
                end
              end else begin
                rdat_d   = sync_eff;
                rown_d   = req_src;
                l2_st_we = 1'b1;
                l2_st_wd = LS_REG;
                l2_sy_we = 1'b1;
                l2_sy_wd = DW'(req_src);
                if (is_inv) begin
                  l2_pl_we = 1'b1;
                  l2_pl_wd = mem_plain;
                end
              end
            end
            OP_REL: begin
              if (is_reg && cur_owner == req_src) begin
                rown_d   = req_src;
                l2_st_we = 1'b1;
                l2_st_wd = LS_DIRTY;
                l2_sy_we = 1'b1;
                l2_sy_wd = req_data;
              end else begin
                rrem_d = 1'b1;
                rown_d = is_reg ? cur_owner : '0;
              end
            end
            OP_L2EV: begin
              if (is_reg) begin
                prev_d = cur_owner;
                fsm_d  = F_PRB;
              end else begin
                if (l2_state == LS_DIRTY) begin
                  mem_sy_we = 1'b1;
                  mem_sy_wd = l2_sync;
                end
                l2_st_we = 1'b1;
                l2_st_wd = LS_INV;
              end
            end
            default: ;
          endcase
        end
      end
      F_PRB: begin
        if (prb_ready) fsm_d = F_WAIT;
      end
      F_WAIT: begin
        if (ack_valid) begin
          fsm_d = F_RSP;
          if (op_q == OP_REG) begin
            l2_sy_we = 1'b1;
            l2_sy_wd = DW'(src_q);
            rdat_d   = ack_data;
            rrem_d   = 1'b1;
            rown_d   = prev_q;
          end else begin
            mem_sy_we = 1'b1;
            mem_sy_wd = ack_data;
            l2_st_we  = 1'b1;
            l2_st_wd  = LS_INV;
          end
        end
      end
      F_RSP: begin
        if (rsp_ready) fsm_d = F_IDLE;
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q  <= F_IDLE;
      op_q   <= OP_RD;
      src_q  <= '0;
      line_q <= '0;
      prev_q <= '0;
      rdat_q <= '0;
      rrem_q <= 1'b0;
      rown_q <= '0;
    end else begin
      fsm_q  <= fsm_d;
      op_q   <= op_d;
      src_q  <= src_d;
      line_q <= line_d;
      prev_q <= prev_d;
      rdat_q <= rdat_d;
      rrem_q <= rrem_d;
      rown_q <= rown_d;
    end
  end

  assign req_ready  = (fsm_q == F_IDLE);
  assign rsp_valid  = (fsm_q == F_RSP);
  assign rsp_dst    = src_q;
  assign rsp_data   = rdat_q;
  assign rsp_remote = rrem_q;
  assign rsp_owner  = rown_q;
  assign prb_valid  = (fsm_q == F_PRB);
  assign prb_dst    = prev_q;
  assign prb_line   = line_q;
  assign prb_evict  = (op_q == OP_L2EV);
  assign ack_ready  = (fsm_q == F_WAIT);
endmodule

// File: rtl/regdir.sv
module regdir
  import regdir_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int DW     = 32,
  parameter int IDW    = 7,
  localparam int IW    = $clog2(NLINES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [2:0]     req_op,
  input  logic [IDW-1:0] req_src,
  input  logic [IW-1:0]  req_line,
  input  logic [DW-1:0]  req_data,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [IDW-1:0] rsp_dst,
  output logic [DW-1:0]  rsp_data,
  output logic           rsp_remote,
  output logic [IDW-1:0] rsp_owner,
  output logic           prb_valid,
  input  logic           prb_ready,
  output logic [IDW-1:0] prb_dst,
  output logic [IW-1:0]  prb_line,
  output logic           prb_evict,
  input  logic           ack_valid,
  output logic           ack_ready,
  input  logic [DW-1:0]  ack_data
);
  logic [IW-1:0] idx;
  lstate_e       l2_state, l2_st_wd;
  logic [DW-1:0] l2_sync, l2_plain, l2_sy_wd, l2_pl_wd;
  logic          l2_st_we, l2_sy_we, l2_pl_we;
  logic [DW-1:0] mem_sync, mem_plain, mem_sy_wd, mem_pl_wd;
  logic          mem_sy_we, mem_pl_we;

  regdir_ctrl #(.NLINES(NLINES), .DW(DW), .IDW(IDW)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_src(req_src), .req_line(req_line), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_dst(rsp_dst),
    .rsp_data(rsp_data), .rsp_remote(rsp_remote), .rsp_owner(rsp_owner),
    .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_dst(prb_dst),
    .prb_line(prb_line), .prb_evict(prb_evict),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_data(ack_data),
    .idx(idx), .l2_state(l2_state), .l2_sync(l2_sync), .l2_plain(l2_plain),
    .l2_st_we(l2_st_we), .l2_st_wd(l2_st_wd), .l2_sy_we(l2_sy_we),
    .l2_sy_wd(l2_sy_wd), .l2_pl_we(l2_pl_we), .l2_pl_wd(l2_pl_wd),
    .mem_sync(mem_sync), .mem_plain(mem_plain),
    .mem_sy_we(mem_sy_we), .mem_sy_wd(mem_sy_wd),
    .mem_pl_we(mem_pl_we), .mem_pl_wd(mem_pl_wd)
  );

  regdir_store #(.NLINES(NLINES), .DW(DW)) store_i (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(idx), .rd_state(l2_state), .rd_sync(l2_sync), .rd_plain(l2_plain),
    .wr_idx(idx), .wr_state_en(l2_st_we), .wr_state(l2_st_wd),
    .wr_sync_en(l2_sy_we), .wr_sync(l2_sy_wd),
    .wr_plain_en(l2_pl_we), .wr_plain(l2_pl_wd)
  );

  regdir_backing #(.NLINES(NLINES), .DW(DW)) mem_i (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(idx), .rd_sync(mem_sync), .rd_plain(mem_plain),
    .wr_idx(idx), .wr_sync_en(mem_sy_we), .wr_sync(mem_sy_wd),
    .wr_plain_en(mem_pl_we), .wr_plain(mem_pl_wd)
  );
endmodule

// File: rtl/regdir_chk.sv
module regdir_chk #(
  parameter int DW  = 32,
  parameter int IDW = 7,
  parameter int IW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [DW-1:0]  rsp_data,
  input logic           rsp_remote,
  input logic [IDW-1:0] rsp_owner,
  input logic           prb_valid,
  input logic           prb_ready,
  input logic [IDW-1:0] prb_dst,
  input logic [IW-1:0]  prb_line,
  input logic           ack_valid,
  input logic           ack_ready
);
  assert_probe_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_valid || ack_ready) |-> !req_ready);

  assert_single_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)
                                   && $stable(rsp_remote) && $stable(rsp_owner)));

  assert_prb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_valid && !prb_ready) |=> (prb_valid && $stable(prb_dst) && $stable(prb_line)));

  assert_prb_to_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_valid && prb_ready) |=> ack_ready);

  assert_ack_to_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ready && ack_valid) |=> rsp_valid);

  assert_outputs_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, rsp_valid, prb_valid, ack_ready}));
endmodule

bind regdir regdir_chk #(.DW(DW), .IDW(IDW), .IW(IW)) chk_i (.*);

// File: tb/regdir_tb_top.sv
module regdir_tb_top;
  localparam int NL = 16, DW = 32, IDW = 7, IW = 4;
  localparam logic [2:0] RD = 3'd0, WR = 3'd1, RG = 3'd2, RL = 3'd3, EV = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, rsp_ready = 0, prb_ready = 0, ack_valid = 0;
  logic [2:0] req_op = 0;
  logic [IDW-1:0] req_src = 0;
  logic [IW-1:0] req_line = 0;
  logic [DW-1:0] req_data = 0, ack_data = 0;
  logic req_ready, rsp_valid, rsp_remote, prb_valid, prb_evict, ack_ready;
  logic [IDW-1:0] rsp_dst, rsp_owner, prb_dst;
  logic [DW-1:0] rsp_data;
  logic [IW-1:0] prb_line;

  always #4 clk = ~clk;

  regdir dut_i (.*);

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model: 0 invalid, 1 valid, 2 dirty, 3 registered
  int unsigned ms_st [NL];
  logic [DW-1:0] ms_sync [NL], ms_plain [NL], mm_sync [NL], mm_plain [NL], l1v [NL];
  logic [IDW-1:0] ms_own [NL];

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected outcome of one request, and model update
  task automatic model(input logic [2:0] op, input logic [IDW-1:0] src,
                       input logic [IW-1:0] ln, input logic [DW-1:0] d,
                       output logic [DW-1:0] e_data, output logic e_rem,
                       output logic [IDW-1:0] e_own, output logic e_prb,
                       output logic [IDW-1:0] e_pdst, output logic e_pev);
    e_data = 0; e_rem = 0; e_own = 0; e_prb = 0; e_pdst = 0; e_pev = 0;
    case (op)
      RD: begin
        if (ms_st[ln] == 0) begin ms_st[ln] = 1; ms_sync[ln] = mm_sync[ln]; ms_plain[ln] = mm_plain[ln]; end
        e_data = ms_plain[ln];
      end
      WR: begin
        if (ms_st[ln] == 0) begin ms_st[ln] = 1; ms_sync[ln] = mm_sync[ln]; end
        ms_plain[ln] = d; mm_plain[ln] = d;
      end
      RG: begin
        if (ms_st[ln] == 3) begin
          if (ms_own[ln] == src) e_own = src;
          else begin
            e_prb = 1; e_pdst = ms_own[ln]; e_data = l1v[ln]; e_rem = 1; e_own = ms_own[ln];
            ms_own[ln] = src;
          end
        end else begin
          if (ms_st[ln] == 0) begin ms_sync[ln] = mm_sync[ln]; ms_plain[ln] = mm_plain[ln]; end
          e_data = ms_sync[ln]; e_own = src; ms_st[ln] = 3; ms_own[ln] = src;
        end
      end
      RL: begin
        if (ms_st[ln] == 3 && ms_own[ln] == src) begin
          ms_sync[ln] = d; ms_st[ln] = 2; e_own = src;
        end else begin
          e_rem = 1; e_own = (ms_st[ln] == 3) ? ms_own[ln] : '0;
        end
      end
      default: begin
        if (ms_st[ln] == 3) begin
          e_prb = 1; e_pev = 1; e_pdst = ms_own[ln]; mm_sync[ln] = l1v[ln];
        end else if (ms_st[ln] == 2) mm_sync[ln] = ms_sync[ln];
        ms_st[ln] = 0;
      end
    endcase
  endtask

  // drive one request, act as the probed L1, check the response
  task automatic do_req(input logic [2:0] op, input logic [IDW-1:0] src,
                        input logic [IW-1:0] ln, input logic [DW-1:0] d, input string tag);
    logic [DW-1:0] e_data; logic e_rem, e_prb, e_pev; logic [IDW-1:0] e_own, e_pdst;
    bit got_prb = 0; logic [IDW-1:0] g_dst = 0; logic g_ev = 0; logic [IW-1:0] g_ln = 0;
    logic [DW-1:0] held;
    model(op, src, ln, d, e_data, e_rem, e_own, e_prb, e_pdst, e_pev);
    req_valid = 1; req_op = op; req_src = src; req_line = ln; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) begin
      if (prb_valid) begin
        got_prb = 1; g_dst = prb_dst; g_ev = prb_evict; g_ln = prb_line;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        prb_ready = 1; @(negedge clk); prb_ready = 0;
        repeat ($urandom_range(1, 3)) @(negedge clk);
        chk(req_ready == 0, "R10 stall during probe", {31'b0, req_ready}, 0);
        ack_valid = 1; ack_data = l1v[ln]; @(negedge clk); ack_valid = 0;
      end else @(negedge clk);
    end
    held = rsp_data;
    repeat ($urandom_range(0, 2)) @(negedge clk);
    chk(rsp_valid && rsp_data == held, "R10 response held", rsp_data, held);
    chk(rsp_data == e_data, {tag, " data"}, rsp_data, e_data);
    chk(rsp_remote == e_rem, {tag, " remote"}, {31'b0, rsp_remote}, {31'b0, e_rem});
    chk(rsp_owner == e_own, {tag, " owner"}, DW'(rsp_owner), DW'(e_own));
    chk(rsp_dst == src, {tag, " dst"}, DW'(rsp_dst), DW'(src));
    chk(got_prb == e_prb, {tag, " probe issued"}, DW'(got_prb), DW'(e_prb));
    if (e_prb && got_prb) begin
      chk(g_dst == e_pdst, {tag, " probe target"}, DW'(g_dst), DW'(e_pdst));
      chk(g_ev == e_pev, {tag, " probe kind"}, DW'(g_ev), DW'(e_pev));
      chk(g_ln == ln, {tag, " probe line"}, DW'(g_ln), DW'(ln));
    end
    rsp_ready = 1; @(negedge clk); rsp_ready = 0;
    // an owner that holds registration keeps updating its value
    if (op == RG) l1v[ln] = $urandom();
  endtask

  function automatic string tag_of(logic [2:0] op);
    case (op)
      RD: return "R2 read";
      WR: return "R3 write";
      RG: return "R4/R5/R6 acquire";
      RL: return "R7 return";
      default: return "R8 evict";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < NL; i++) begin
      ms_st[i] = 0; ms_sync[i] = 0; ms_plain[i] = 0; mm_sync[i] = 0; mm_plain[i] = 0;
      l1v[i] = 0; ms_own[i] = 0;
    end
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1 req_ready", DW'(req_ready), 1);
    chk(rsp_valid == 0, "R1 rsp_valid", DW'(rsp_valid), 0);
    chk(prb_valid == 0, "R1 prb_valid", DW'(prb_valid), 0);
    do_req(RD, 7'd1, 4'd0, 0, "R1 memory zero / R2 fill");
    // R3 write-through survives eviction
    do_req(WR, 7'd1, 4'd1, 32'hA5A5_0001, "R3 write");
    do_req(EV, 7'd1, 4'd1, 0, "R8 evict valid");
    do_req(RD, 7'd2, 4'd1, 0, "R3 refill after write");
    // R4 fresh grant, R5 self re-acquire
    do_req(RG, 7'd3, 4'd2, 0, "R4 fresh grant");
    do_req(RG, 7'd3, 4'd2, 0, "R5 self acquire");
    // R9 plain access to registered line, owner untouched
    do_req(WR, 7'd9, 4'd2, 32'h1234_5678, "R9 write registered");
    do_req(RD, 7'd9, 4'd2, 0, "R9 read registered");
    // R6 transfer from core 3 to core 100 (probe must target 3)
    do_req(RG, 7'd100, 4'd2, 0, "R6 transfer");
    // R7 return from non-owner ignored, then from owner
    do_req(RL, 7'd3, 4'd2, 32'hDEAD_0000, "R7 non-owner return");
    do_req(RL, 7'd100, 4'd2, l1v[2], "R7 owner return");
    do_req(RG, 7'd5, 4'd2, 0, "R7 value after return");
    // R8 forced eviction of registered line, then refill
    do_req(EV, 7'd0, 4'd2, 0, "R8 evict registered");
    do_req(RG, 7'd6, 4'd2, 0, "R8 refill after evict");
    // R8 dirty write-back
    do_req(RL, 7'd6, 4'd2, 32'hBEEF_0042, "R7 owner return");
    do_req(EV, 7'd0, 4'd2, 0, "R8 evict dirty");
    do_req(RG, 7'd127, 4'd2, 0, "R8 dirty refill");
    do_req(RL, 7'd4, 4'd15, 0, "R7 return on invalid");
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [2:0] op; logic [IDW-1:0] src; logic [IW-1:0] ln; logic [DW-1:0] d;
      op  = 3'($urandom_range(0, 4));
      src = ($urandom_range(0, 3) == 0) ? 7'($urandom()) : 7'($urandom_range(0, 3));
      ln  = 4'($urandom_range(0, 7));
      d   = $urandom();
      if (op == RL && ms_st[ln] == 3 && $urandom_range(0, 1) == 1) begin
        src = ms_own[ln]; d = l1v[ln];
      end
      do_req(op, src, ln, d, tag_of(op));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule